// File: doc/BRIEF.md
# Keyed Flash Control Front-End

This block is the register face of an embedded flash controller. Software reaches it through a plain 32-bit register port. The block holds a control register, a status register and an option word. Every write to the control register is refused until software unlocks it. To unlock it, software writes two fixed key values to a key register, in the right order. The option word has its own lock and its own pair of keys. Writing a one to a lock bit sets that lock again.

While the control register is unlocked, software picks one operation: program, page erase or mass erase. For a page erase it also chooses the page and the bank. Setting the start bit launches the operation. The flash array is modelled by a busy timer whose latency depends on the operation. While the timer runs, the block drives the operation code, page and bank towards the array. When the timer finishes, an end-of-operation flag is raised. A bad start request raises a sticky sequence error instead. Both flags stay set until software writes a one to them.

Register offsets on `bus_addr`: status 0x10, control 0x14, main key 0x08, option key 0x0C, option word 0x20. Reads are combinational from `bus_addr`. A write is taken on the rising clock edge where `bus_wr` is high.

Top module: `flk_ctrl_regs`

## Requirements
- R1: After reset the control register reads 0xC000_0000, with bit 31 (main lock) and bit 30 (option lock) set. Status reads 0, the option word reads `OPT_RESET`, and `flash_busy` is low.
- R2: The main lock clears only when 0x45670123 and then 0xCDEF89AB are written to offset 0x08.
- R3: If a wrong value, or the right keys in the wrong order, reach a key register, that lock stays set. All later writes to that key register are then ignored until reset.
- R4: The option lock (control bit 30) clears only when 0x08192A3B and then 0x4C5D6E7F are written to offset 0x0C. This is independent of the main lock.
- R5: A write to the option word at 0x20 takes effect only while the option lock is clear.
- R6: While the main lock is set, control writes change nothing and launch nothing.
- R7: An unlocked control write with bit 31 set relocks the main lock and changes no other field. An unlocked control write with bit 30 set relocks the option lock. After a relock, the key sequence unlocks again.
- R8: The control fields are: program at bit 0, page erase at bit 1, bank-1 mass erase at bit 2, page number at bits 3 upward (`PAGE_W` bits), bank select at bit 11 and bank-2 mass erase at bit 15. All of them read back as written. Start (bit 16) always reads 0.
- R9: A start with page erase selected holds `flash_busy` and status bit 16 high for exactly `PAGE_LAT` cycles. During that time `flash_op` is 2, `flash_page` shows the page, and `flash_bank` is 2'b10 if bank select is set, else 2'b01.
- R10: A start with program selected gives `flash_op` 1 for `PROG_LAT` cycles. A start with mass erase selected gives `flash_op` 3 for `MASS_LAT` cycles, with `flash_bank` = {bit 15, bit 2}.
- R11: Status bit 0 (end of operation) is set on the clock edge where busy falls, and it stays set.
- R12: A start while busy sets status bit 7 (sequence error). It launches nothing: the running operation keeps its code and its end time.
- R13: A start with no operation selected, or with more than one selected, sets status bit 7 and launches nothing.
- R14: Writing a one to status bits 0, 1 or 3 to 7 clears that bit. Writing a zero leaves it unchanged. Busy (bit 16) ignores status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| flash_busy | output | 1 | Array operation in progress |
| flash_op | output | 2 | 0 idle, 1 program, 2 page erase, 3 mass erase |
| flash_page | output | PAGE_W | Page being erased |
| flash_bank | output | 2 | Bank mask of the running operation |

## Verification
A register write is driven between edges and lands on the next rising edge. Its effect on any register, lock or flag can therefore be read at the falling edge that follows. The bench reads the combinational port one nanosecond after that falling edge. After a start, `flash_busy` is first high at that same falling edge. The bench counts the falling edges at which busy is high and expects the operation's latency exactly. The end-of-operation flag is checked at the first falling edge where busy reads low. For a second start issued one cycle into an operation, the bench expects the remaining busy count to be the latency minus one.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [31:0] MAIN_KEY_A = 32'h4567_0123;
  localparam logic [31:0] MAIN_KEY_B = 32'hCDEF_89AB;
  localparam logic [31:0] OPT_KEY_A  = 32'h0819_2A3B;
  localparam logic [31:0] OPT_KEY_B  = 32'h4C5D_6E7F;

  localparam int OFF_MKEY = 'h08;
  localparam int OFF_OKEY = 'h0C;
  localparam int OFF_STAT = 'h10;
  localparam int OFF_CTRL = 'h14;
  localparam int OFF_OPTW = 'h20;

  // control bit positions
  localparam int CB_PROG  = 0;
  localparam int CB_PERS  = 1;
  localparam int CB_MAS1  = 2;
  localparam int CB_PAGE  = 3;
  localparam int CB_BANK  = 11;
  localparam int CB_MAS2  = 15;
  localparam int CB_GO    = 16;
  localparam int CB_OLOCK = 30;
  localparam int CB_MLOCK = 31;

  // status bit positions
  localparam int SB_EOP  = 0;
  localparam int SB_SEQ  = 7;
  localparam int SB_BUSY = 16;

  // bits 0,1,3..7 are write-one-to-clear flags
  localparam logic [7:0] STICKY_MASK = 8'hFB;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_PAGE = 2'd2,
    OP_MASS = 2'd3
  } flk_op_e;
endpackage

// File: rtl/flk_key_gate.sv
module flk_key_gate #(
  parameter logic [31:0] KEY_A = 32'h0,
  parameter logic [31:0] KEY_B = 32'h1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        relock,
  output logic        locked
);
  typedef enum logic [1:0] {KS_WANT_A, KS_WANT_B, KS_OPEN, KS_DEAD} ks_e;
  ks_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= KS_WANT_A;
    end else if (key_wr) begin
      case (st)
        KS_WANT_A: st <= (key_data == KEY_A) ? KS_WANT_B : KS_DEAD;
        KS_WANT_B: st <= (key_data == KEY_B) ? KS_OPEN : KS_DEAD;
        default:   st <= st;  // open or dead: key writes have no effect
      endcase
    end else if (relock && st != KS_DEAD) begin
      st <= KS_WANT_A;
    end
  end

  assign locked = (st != KS_OPEN);

  // R2/R4: a lock can only open on the edge that takes the second key
  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(key_wr) && $past(key_data) == KEY_B));

  // R3: after a bad key the lock never opens again before reset
  p_dead_stays_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == KS_DEAD) |=> locked);
endmodule

// File: rtl/flk_op_timer.sv
module flk_op_timer
  import flk_pkg::*;
#(
  parameter int PROG_LAT = 4,
  parameter int PAGE_LAT = 8,
  parameter int MASS_LAT = 16,
  parameter int PAGE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  flk_op_e           launch_op,
  input  logic [PAGE_W-1:0] launch_page,
  input  logic [1:0]        launch_bank,
  output logic              busy,
  output logic              done,
  output flk_op_e           op,
  output logic [PAGE_W-1:0] page,
  output logic [1:0]        bank
);
  localparam int MAX_AB  = (PROG_LAT > PAGE_LAT) ? PROG_LAT : PAGE_LAT;
  localparam int MAX_LAT = (MAX_AB > MASS_LAT) ? MAX_AB : MASS_LAT;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (launch_op)
      OP_PROG: load_val = CNT_W'(PROG_LAT - 1);
      OP_PAGE: load_val = CNT_W'(PAGE_LAT - 1);
      default: load_val = CNT_W'(MASS_LAT - 1);
    endcase
  end

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      op   <= OP_IDLE;
      page <= '0;
      bank <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1;
      cnt  <= load_val;
      op   <= launch_op;
      page <= launch_page;
      bank <= launch_bank;
    end else if (done) begin
      busy <= 1'b0;
      op   <= OP_IDLE;
      page <= '0;
      bank <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9: the operation presented to the array holds still until it ends
  p_op_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(op) && $stable(page) && $stable(bank)));

  // R12: nothing is launched on top of a running operation
  p_no_launch_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy);
endmodule

// File: rtl/flk_sticky_flags.sv
module flk_sticky_flags
  import flk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_eop,
  input  logic       set_seq,
  input  logic       clr_wr,
  input  logic [7:0] clr_data,
  output logic [7:0] flags
);
  logic [7:0] set_vec;
  logic [7:0] clr_vec;

  always_comb begin
    set_vec         = '0;
    set_vec[SB_EOP] = set_eop;
    set_vec[SB_SEQ] = set_seq;
    clr_vec         = clr_wr ? (clr_data & STICKY_MASK) : '0;
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end

  // R14: a one written to a flag with no new event clears it
  p_w1c_clears_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[SB_SEQ] && !set_seq) |=> !flags[SB_SEQ]);

  // R14: without a clear, a flag never drops
  p_flag_sticky_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[SB_EOP] && !(clr_wr && clr_data[SB_EOP])) |=> flags[SB_EOP]);
endmodule

// File: rtl/flk_ctrl_regs.sv
module flk_ctrl_regs
  import flk_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          PAGE_W    = 8,
  parameter int          PROG_LAT  = 4,
  parameter int          PAGE_LAT  = 8,
  parameter int          MASS_LAT  = 16,
  parameter logic [31:0] OPT_RESET = 32'hFFEF_F8AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              flash_busy,
  output logic [1:0]        flash_op,
  output logic [PAGE_W-1:0] flash_page,
  output logic [1:0]        flash_bank
);
  localparam int NUM_LOCKS = 2;

  // address decode
  logic hit_mkey, hit_okey, hit_stat, hit_ctrl, hit_optw;
  assign hit_mkey = (bus_addr == ADDR_W'(OFF_MKEY));
  assign hit_okey = (bus_addr == ADDR_W'(OFF_OKEY));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_optw = (bus_addr == ADDR_W'(OFF_OPTW));

  logic lock_main, lock_opt;
  logic ctrl_wr_ok;
  assign ctrl_wr_ok = bus_wr && hit_ctrl && !lock_main;

  // two key gates, index 0 = main, 1 = option
  logic [NUM_LOCKS-1:0] gate_wr, gate_relock, gate_locked;
  assign gate_wr[0]     = bus_wr && hit_mkey;
  assign gate_wr[1]     = bus_wr && hit_okey;
  assign gate_relock[0] = ctrl_wr_ok && bus_wdata[CB_MLOCK];
  assign gate_relock[1] = ctrl_wr_ok && bus_wdata[CB_OLOCK];

  for (genvar g = 0; g < NUM_LOCKS; g++) begin : g_lock
    localparam logic [31:0] KA = (g == 0) ? MAIN_KEY_A : OPT_KEY_A;
    localparam logic [31:0] KB = (g == 0) ? MAIN_KEY_B : OPT_KEY_B;
    flk_key_gate #(.KEY_A(KA), .KEY_B(KB)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (gate_wr[g]),
      .key_data (bus_wdata),
      .relock   (gate_relock[g]),
      .locked   (gate_locked[g])
    );
  end

  assign lock_main = gate_locked[0];
  assign lock_opt  = gate_locked[1];

  // control fields
  logic              f_prog, f_pers, f_mas1, f_mas2, f_bank;
  logic [PAGE_W-1:0] f_page;
  logic              field_wr;
  assign field_wr = ctrl_wr_ok && !bus_wdata[CB_MLOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_prog <= 1'b0;
      f_pers <= 1'b0;
      f_mas1 <= 1'b0;
      f_mas2 <= 1'b0;
      f_bank <= 1'b0;
      f_page <= '0;
    end else if (field_wr) begin
      f_prog <= bus_wdata[CB_PROG];
      f_pers <= bus_wdata[CB_PERS];
      f_mas1 <= bus_wdata[CB_MAS1];
      f_mas2 <= bus_wdata[CB_MAS2];
      f_bank <= bus_wdata[CB_BANK];
      f_page <= bus_wdata[CB_PAGE +: PAGE_W];
    end
  end

  // start decision, taken from the write data itself
  logic    start_req, sel_ok, launch, seq_set, w_mass;
  flk_op_e launch_op;
  logic [1:0] launch_bank;

  assign w_mass    = bus_wdata[CB_MAS1] | bus_wdata[CB_MAS2];
  assign start_req = field_wr && bus_wdata[CB_GO];
  assign sel_ok    = ($countones({bus_wdata[CB_PROG], bus_wdata[CB_PERS], w_mass}) == 1);
  assign launch    = start_req && sel_ok && !flash_busy;
  assign seq_set   = start_req && (flash_busy || !sel_ok);

  always_comb begin
    if (bus_wdata[CB_PROG])      launch_op = OP_PROG;
    else if (bus_wdata[CB_PERS]) launch_op = OP_PAGE;
    else                         launch_op = OP_MASS;
    if (launch_op == OP_MASS) launch_bank = {bus_wdata[CB_MAS2], bus_wdata[CB_MAS1]};
    else                      launch_bank = bus_wdata[CB_BANK] ? 2'b10 : 2'b01;
  end

  logic    op_done;
  flk_op_e op_now;

  flk_op_timer #(
    .PROG_LAT (PROG_LAT),
    .PAGE_LAT (PAGE_LAT),
    .MASS_LAT (MASS_LAT),
    .PAGE_W   (PAGE_W)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_op   (launch_op),
    .launch_page (bus_wdata[CB_PAGE +: PAGE_W]),
    .launch_bank (launch_bank),
    .busy        (flash_busy),
    .done        (op_done),
    .op          (op_now),
    .page        (flash_page),
    .bank        (flash_bank)
  );
  assign flash_op = op_now;

  // status flags
  logic [7:0] sts_flags;
  flk_sticky_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_eop  (op_done),
    .set_seq  (seq_set),
    .clr_wr   (bus_wr && hit_stat),
    .clr_data (bus_wdata[7:0]),
    .flags    (sts_flags)
  );

  // option word
  logic [31:0] opt_word;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                opt_word <= OPT_RESET;
    else if (bus_wr && hit_optw && !lock_opt)  opt_word <= bus_wdata;
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CB_MLOCK]           = lock_main;
      bus_rdata[CB_OLOCK]           = lock_opt;
      bus_rdata[CB_PROG]            = f_prog;
      bus_rdata[CB_PERS]            = f_pers;
      bus_rdata[CB_MAS1]            = f_mas1;
      bus_rdata[CB_MAS2]            = f_mas2;
      bus_rdata[CB_BANK]            = f_bank;
      bus_rdata[CB_PAGE +: PAGE_W]  = f_page;
    end else if (hit_stat) begin
      bus_rdata[7:0]     = sts_flags;
      bus_rdata[SB_BUSY] = flash_busy;
    end else if (hit_optw) begin
      bus_rdata = opt_word;
    end
  end

  // R6: a locked control register keeps all of its fields
  p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_main |=> $stable({f_prog, f_pers, f_mas1, f_mas2, f_bank, f_page}));

  // R11: end of operation is flagged on the edge where busy drops
  p_eop_at_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_busy) |-> sts_flags[SB_EOP]);

  // R12: a start while busy raises the sequence error
  p_busy_start_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && flash_busy) |=> sts_flags[SB_SEQ]);

  // R5: a locked option word does not move
  p_opt_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_opt |=> $stable(opt_word));
endmodule

// File: tb/flk_ctrl_regs_bench.sv
module flk_ctrl_regs_bench;
  localparam int PROG_LAT = 4;
  localparam int PAGE_LAT = 8;
  localparam int MASS_LAT = 16;
  localparam logic [31:0] OPT_RST = 32'hFFEF_F8AA;

  localparam logic [7:0] A_MKEY = 8'h08, A_OKEY = 8'h0C, A_STAT = 8'h10,
                         A_CTRL = 8'h14, A_OPTW = 8'h20;
  localparam logic [31:0] MK1 = 32'h4567_0123, MK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B, OK2 = 32'h4C5D_6E7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        flash_busy;
  logic [1:0]  flash_op;
  logic [7:0]  flash_page;
  logic [1:0]  flash_bank;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flk_ctrl_regs #(
    .ADDR_W(8), .PAGE_W(8), .PROG_LAT(PROG_LAT), .PAGE_LAT(PAGE_LAT),
    .MASS_LAT(MASS_LAT), .OPT_RESET(OPT_RST)
  ) u_flk_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flash_busy(flash_busy),
    .flash_op(flash_op), .flash_page(flash_page), .flash_bank(flash_bank)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (flash_busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 32'hC000_0000);
    rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
    rd(A_OPTW, v); chk("R1 option after reset", v, OPT_RST);
    chk("R1 busy after reset", 32'(flash_busy), 32'h0);
  endtask

  task automatic t_locked_ctrl();
    logic [31:0] v;
    wr(A_CTRL, 32'h0001_0002);
    rd(A_CTRL, v); chk("R6 locked ctrl write ignored", v, 32'hC000_0000);
    chk("R6 locked start launches nothing", 32'(flash_busy), 32'h0);
    rd(A_STAT, v); chk("R6 locked start no flags", v, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] v;
    wr(A_MKEY, MK1);
    rd(A_CTRL, v); chk("R2 still locked after first key", v, 32'hC000_0000);
    wr(A_MKEY, MK2);
    rd(A_CTRL, v); chk("R2 unlocked after key pair", v, 32'h4000_0000);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_8FFF);
    rd(A_CTRL, v); chk("R8 all fields set", v, 32'h4000_8FFF);
    wr(A_CTRL, 32'h0000_0000);
    rd(A_CTRL, v); chk("R8 all fields cleared", v, 32'h4000_0000);
  endtask

  task automatic t_page_erase();
    logic [31:0] v;
    int n;
    wr(A_CTRL, (32'h1 << 16) | (32'h1 << 11) | (32'h5A << 3) | 32'h2);
    chk("R9 op code page erase", 32'(flash_op), 32'h2);
    chk("R9 page on array", 32'(flash_page), 32'h5A);
    chk("R9 bank mask", 32'(flash_bank), 32'h2);
    rd(A_STAT, v); chk("R9 status busy, no eop yet", v, 32'h0001_0000);
    rd(A_CTRL, v); chk("R8 start reads zero", v, 32'h4000_0AD2);
    count_busy(n);
    chk("R9 page erase busy length", 32'(n), 32'(PAGE_LAT));
    rd(A_STAT, v); chk("R11 eop after busy falls", v, 32'h1);
    chk("R9 op idle after end", 32'(flash_op), 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(A_STAT, 32'h0001_0000);
    rd(A_STAT, v); chk("R14 zero write keeps eop", v, 32'h1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); chk("R14 one write clears eop", v, 32'h0);
  endtask

  task automatic t_other_ops();
    logic [31:0] v;
    int n;
    wr(A_CTRL, 32'h0001_0001);
    chk("R10 program op code", 32'(flash_op), 32'h1);
    count_busy(n);
    chk("R10 program busy length", 32'(n), 32'(PROG_LAT));
    wr(A_STAT, 32'hFF);
    wr(A_CTRL, 32'h0001_8004);
    chk("R10 mass op code", 32'(flash_op), 32'h3);
    chk("R10 mass bank mask", 32'(flash_bank), 32'h3);
    count_busy(n);
    chk("R10 mass busy length", 32'(n), 32'(MASS_LAT));
    rd(A_STAT, v); chk("R11 eop after mass erase", v, 32'h1);
    wr(A_STAT, 32'hFF);
  endtask

  task automatic t_busy_start();
    logic [31:0] v;
    int n;
    wr(A_CTRL, 32'h0001_0002 | (32'h11 << 3));
    wr(A_CTRL, 32'h0001_0001);
    rd(A_STAT, v); chk("R12 seq error while busy", v, 32'h0001_0080);
    chk("R12 running op unchanged", 32'(flash_op), 32'h2);
    chk("R12 running page unchanged", 32'(flash_page), 32'h11);
    count_busy(n);
    chk("R12 original end time kept", 32'(n), 32'(PAGE_LAT - 1));
    rd(A_STAT, v); chk("R11 eop and seq both held", v, 32'h81);
    wr(A_STAT, 32'h80);
    rd(A_STAT, v); chk("R14 seq cleared, eop kept", v, 32'h1);
    wr(A_STAT, 32'h1);
  endtask

  task automatic t_bad_select();
    logic [31:0] v;
    wr(A_CTRL, 32'h0001_0003);
    chk("R13 two ops: nothing launched", 32'(flash_busy), 32'h0);
    rd(A_STAT, v); chk("R13 two ops: seq error", v, 32'h80);
    wr(A_STAT, 32'h80);
    wr(A_CTRL, 32'h0001_0000);
    chk("R13 no op: nothing launched", 32'(flash_busy), 32'h0);
    rd(A_STAT, v); chk("R13 no op: seq error", v, 32'h80);
    wr(A_STAT, 32'h80);
  endtask

  task automatic t_relock();
    logic [31:0] v;
    wr(A_CTRL, 32'h0000_0804);
    wr(A_CTRL, 32'h8000_0002);
    rd(A_CTRL, v); chk("R7 relock keeps fields", v, 32'hC000_0804);
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    rd(A_CTRL, v); chk("R7 re-unlock after relock", v, 32'h4000_0804);
  endtask

  task automatic t_option();
    logic [31:0] v;
    wr(A_OPTW, 32'h1234_5678);
    rd(A_OPTW, v); chk("R5 locked option ignored", v, OPT_RST);
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    rd(A_CTRL, v); chk("R4 option unlocked", v, 32'h0000_0804);
    wr(A_OPTW, 32'h1234_5678);
    rd(A_OPTW, v); chk("R5 unlocked option written", v, 32'h1234_5678);
    wr(A_CTRL, 32'h4000_0804);
    rd(A_CTRL, v); chk("R7 option relocked", v, 32'h4000_0804);
    wr(A_OPTW, 32'hAAAA_5555);
    rd(A_OPTW, v); chk("R5 relocked option ignored", v, 32'h1234_5678);
  endtask

  task automatic t_bad_keys();
    logic [31:0] v;
    wr(A_CTRL, 32'h8000_0000);
    wr(A_MKEY, MK2);
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    rd(A_CTRL, v); chk("R3 wrong order stays locked", v, 32'hC000_0804);
    wr(A_OKEY, OK1);
    wr(A_OKEY, 32'hDEAD_BEEF);
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    wr(A_OPTW, 32'h0);
    rd(A_OPTW, v); chk("R3 bad option key stays locked", v, 32'h1234_5678);
    do_reset();
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    rd(A_CTRL, v); chk("R3 keys work again after reset", v, 32'h4000_0000);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_locked_ctrl();
    t_unlock();
    t_fields();
    t_page_erase();
    t_w1c();
    t_other_ops();
    t_busy_start();
    t_bad_select();
    t_relock();
    t_option();
    t_bad_keys();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule